// File: doc/BRIEF.md
# Digit-Serial BCD Result Scanner

This block presents a latched multi-digit decimal result to an outside reader one digit at a time. It places each digit on a 4-bit BCD bus and steps through the digit positions, least significant first. A marker flags the first position of every scan. A data-good flag says whether the digits on the bus belong to a settled result, and an overflow flag travels with that result.

The scan is stepped by one of two sources. The first is an internal scan clock made by dividing the system clock, and this clock is also driven out. The second is an external scan clock, used whenever the internal one is disabled. Both the source select and the external clock are synchronized, and the scan steps on exactly one source in any cycle. A change of source therefore neither skips a digit nor repeats one. A separate counter holds the result and raises a busy level while it writes a new value. The block drops data-good for that time and restores it when the scan next arrives at the first position.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While rst_n is low, the scan is forced to position 0, so `slot0_o` is 1, and `data_good_o` and `overflow_o` are 0.
- R2: While the scan is at position k, `digit_o` carries bits [4k+3:4k] of `result_i`, with bit 0 of the bus weighted 1, bit 1 weighted 2, bit 2 weighted 4 and bit 3 weighted 8. Position 0 is the least significant decimal digit.
- R3: `slot0_o` is high exactly while the scan is at position 0. The scan steps 0,1,...,NUM_DIGITS-1 and then wraps to 0.
- R4: With the internal source selected, the scan steps once every SCAN_DIV clock cycles. `scan_clk_o` is high for the first SCAN_DIV/2 cycles of each step period and low for the rest.
- R5: While `int_scan_dis_i` is high (it passes a 2-flop synchronizer), the internal source stops and `scan_clk_o` stays low. Each rising edge of `ext_scan_clk_i` steps the scan by exactly one position, on the third clock edge after the input rises.
- R6: A change of source neither skips nor repeats a position. After `int_scan_dis_i` falls, the first internal step lands on clock edge SCAN_DIV+2 counted from the fall.
- R7: A cycle with `latch_busy_i` high forces `data_good_o` low on the next clock edge.
- R8: After `latch_busy_i` is low, `data_good_o` rises on the step that brings the scan to position 0. `overflow_o` takes the value of `overflow_i` on that same step.
- R9: `overflow_o` is 0 whenever `data_good_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_i | input | NUM_DIGITS*DIGIT_W | Latched BCD result, position 0 in the low nibble |
| overflow_i | input | 1 | Overflow flag of the latched result |
| latch_busy_i | input | 1 | High while a new result is being written |
| int_scan_dis_i | input | 1 | High selects the external scan clock |
| ext_scan_clk_i | input | 1 | External scan clock, asynchronous |
| scan_clk_o | output | 1 | Internal scan clock out, low while disabled |
| digit_o | output | DIGIT_W | BCD digit of the current position |
| slot0_o | output | 1 | High during position 0 |
| data_good_o | output | 1 | Presented digits belong to a settled result |
| overflow_o | output | 1 | Overflow flag of the presented result |

## Verification
The bench builds the block with NUM_DIGITS=7, DIGIT_W=4 and SCAN_DIV=4. With these values, a whole internal scan lasts only 28 cycles. The bench can then time the marker width, the scan period and the scan clock duty cycle directly. It can also count the exact edge on which the first step lands after a change of source. Seven digits still make the wrap from position 6 back to 0 a real case, and the bench uses results whose digits all differ so that any skipped or repeated position shows up on the digit bus.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } scan_src_e;

  // Next position of a scan over `count` positions, wrapping to 0.
  function automatic int wrap_next(input int cur, input int count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction

  // Width needed to hold 0..count-1, never below 1.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int SCAN_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_dis_i,
  input  logic ext_clk_i,
  output logic tick_o,
  output logic use_ext_o,
  output logic scan_clk_o
);
  import bcd_scan_pkg::*;

  localparam int DIV_W = idx_width(SCAN_DIV);
  localparam int HALF  = SCAN_DIV / 2;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(HALF);

  logic             dis_s1;
  scan_src_e        src_q;
  logic [2:0]       ext_sh;
  logic [DIV_W-1:0] div_cnt;
  logic             int_tick;
  logic             ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_s1  <= 1'b0;
      src_q   <= SRC_INT;
      ext_sh  <= '0;
      div_cnt <= '0;
    end else begin
      dis_s1 <= int_dis_i;
      src_q  <= dis_s1 ? SRC_EXT : SRC_INT;
      ext_sh <= {ext_sh[1:0], ext_clk_i};
      if (src_q == SRC_EXT) begin
        div_cnt <= '0;
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  assign int_tick   = (src_q == SRC_INT) && (div_cnt == DIV_LAST);
  assign ext_tick   = (src_q == SRC_EXT) && ext_sh[1] && !ext_sh[2];
  assign tick_o     = int_tick || ext_tick;
  assign use_ext_o  = (src_q == SRC_EXT);
  assign scan_clk_o = (src_q == SRC_INT) && (div_cnt < DIV_HALF);

endmodule

// File: rtl/scan_slot_ctr.sv
module scan_slot_ctr #(
  parameter int NUM_DIGITS = 7,
  parameter int SLOT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wrap_o,
  output logic              slot0_o
);
  import bcd_scan_pkg::*;

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_DIGITS - 1);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (tick_i) begin
      slot_q <= SLOT_W'(wrap_next(int'(slot_q), NUM_DIGITS));
    end
  end

  assign slot_o  = slot_q;
  assign wrap_o  = tick_i && (slot_q == SLOT_LAST);
  assign slot0_o = (slot_q == '0);

endmodule

// File: rtl/scan_valid_ctl.sv
module scan_valid_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic ovf_i,
  input  logic wrap_i,
  output logic data_good_o,
  output logic overflow_o
);

  logic good_q;
  logic ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (busy_i) begin
      good_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (wrap_i) begin
      good_q <= 1'b1;
      ovf_q  <= ovf_i;
    end
  end

  assign data_good_o = good_q;
  assign overflow_o  = ovf_q;

endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
  parameter int NUM_DIGITS = 7,
  parameter int DIGIT_W    = 4,
  parameter int SCAN_DIV   = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] result_i,
  input  logic                          overflow_i,
  input  logic                          latch_busy_i,
  input  logic                          int_scan_dis_i,
  input  logic                          ext_scan_clk_i,
  output logic                          scan_clk_o,
  output logic [DIGIT_W-1:0]            digit_o,
  output logic                          slot0_o,
  output logic                          data_good_o,
  output logic                          overflow_o
);
  import bcd_scan_pkg::*;

  localparam int SLOT_W = idx_width(NUM_DIGITS);

  // Internal events, named for the checker
  logic              scan_tick;
  logic              scan_wrap;
  logic              use_ext;
  logic [SLOT_W-1:0] scan_slot;
  logic [DIGIT_W-1:0] digit_arr [NUM_DIGITS];

  scan_tick_gen #(
    .SCAN_DIV(SCAN_DIV)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_dis_i (int_scan_dis_i),
    .ext_clk_i (ext_scan_clk_i),
    .tick_o    (scan_tick),
    .use_ext_o (use_ext),
    .scan_clk_o(scan_clk_o)
  );

  scan_slot_ctr #(
    .NUM_DIGITS(NUM_DIGITS),
    .SLOT_W    (SLOT_W)
  ) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (scan_tick),
    .slot_o (scan_slot),
    .wrap_o (scan_wrap),
    .slot0_o(slot0_o)
  );

  scan_valid_ctl u_valid (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (latch_busy_i),
    .ovf_i      (overflow_i),
    .wrap_i     (scan_wrap),
    .data_good_o(data_good_o),
    .overflow_o (overflow_o)
  );

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign digit_arr[g] = result_i[g*DIGIT_W +: DIGIT_W];
  end

  always_comb begin
    digit_o = '0;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      if (scan_slot == SLOT_W'(k)) digit_o = digit_arr[k];
    end
  end

endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              scan_tick,
  input logic              scan_wrap,
  input logic              use_ext,
  input logic [SLOT_W-1:0] scan_slot,
  input logic              scan_clk_o,
  input logic              slot0_o,
  input logic              data_good_o,
  input logic              overflow_o
);

  p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(scan_slot));

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_wrap |=> (scan_slot == '0));

  p_marker_after_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot0_o) |-> $past(scan_wrap));

  p_ext_quiet_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext |-> !scan_clk_o);

  p_busy_clears_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !data_good_o);

  p_good_rises_at_slot0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_good_o) |-> (slot0_o && $past(scan_wrap)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_good_o |-> !overflow_o);

endmodule

bind bcd_digit_scanner scan_checker #(
  .SLOT_W(SLOT_W)
) i_scan_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (latch_busy_i),
  .scan_tick  (scan_tick),
  .scan_wrap  (scan_wrap),
  .use_ext    (use_ext),
  .scan_slot  (scan_slot),
  .scan_clk_o (scan_clk_o),
  .slot0_o    (slot0_o),
  .data_good_o(data_good_o),
  .overflow_o (overflow_o)
);

// File: tb/test_bcd_digit_scanner.sv
`timescale 1ns/1ps
module test_bcd_digit_scanner;

  localparam int ND  = 7;
  localparam int DW  = 4;
  localparam int DIV = 4;
  localparam int NV  = 6;
  localparam int unsigned VEC_VAL [NV] = '{0, 9999999, 1234567, 5000001, 8, 3060900};
  localparam bit          VEC_OVF [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam int unsigned RAMP = 7654321; // position k shows k+1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND*DW-1:0] result_i = '0;
  logic overflow_i = 1'b0;
  logic latch_busy_i = 1'b0;
  logic int_scan_dis_i = 1'b0;
  logic ext_scan_clk_i = 1'b0;
  logic scan_clk_o;
  logic [DW-1:0] digit_o;
  logic slot0_o;
  logic data_good_o;
  logic overflow_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bcd_digit_scanner #(
    .NUM_DIGITS(ND),
    .DIGIT_W   (DW),
    .SCAN_DIV  (DIV)
  ) i_bcd_digit_scanner (
    .clk           (clk),
    .rst_n         (rst_n),
    .result_i      (result_i),
    .overflow_i    (overflow_i),
    .latch_busy_i  (latch_busy_i),
    .int_scan_dis_i(int_scan_dis_i),
    .ext_scan_clk_i(ext_scan_clk_i),
    .scan_clk_o    (scan_clk_o),
    .digit_o       (digit_o),
    .slot0_o       (slot0_o),
    .data_good_o   (data_good_o),
    .overflow_o    (overflow_o)
  );

  function automatic logic [ND*DW-1:0] to_bcd(input int unsigned v);
    logic [ND*DW-1:0] r;
    int unsigned t;
    t = v;
    r = '0;
    for (int k = 0; k < ND; k++) begin
      r[k*DW +: DW] = DW'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int dec_digit(input int unsigned v, input int k);
    int unsigned t;
    t = v;
    for (int j = 0; j < k; j++) t = t / 10;
    return int'(t % 10);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_scan_clk_i = 1'b1;
    repeat (4) @(negedge clk);
    ext_scan_clk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int d;
    int hi_cnt;
    result_i = to_bcd(RAMP);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 slot0 in reset", int'(slot0_o), 1);
    chk("R1 data_good in reset", int'(data_good_o), 0);
    chk("R1 overflow in reset", int'(overflow_o), 0);
    chk("R2 digit at position 0", int'(digit_o), 1);
    rst_n = 1'b1;

    // R4 / R3: internal cadence, marker width, period, scan clock duty
    while (slot0_o) @(negedge clk);
    while (!slot0_o) @(negedge clk);
    hi_cnt = 0;
    for (int c = 0; c < ND * DIV; c++) begin
      chk("R4 digit follows internal steps", int'(digit_o), c / DIV + 1);
      chk("R3 slot0 only at position 0", int'(slot0_o), (c < DIV) ? 1 : 0);
      chk("R4 scan clock phase", int'(scan_clk_o), ((c % DIV) < DIV / 2) ? 1 : 0);
      if (scan_clk_o) hi_cnt++;
      @(negedge clk);
    end
    chk("R3 scan wraps after last position", int'(slot0_o), 1);
    chk("R4 scan clock high count per scan", hi_cnt, ND * (DIV / 2));

    // R5: switch to external, internal source quiet
    int_scan_dis_i = 1'b1;
    repeat (4) @(negedge clk);
    d = int'(digit_o);
    repeat (40) @(negedge clk);
    chk("R5 no step without external edge", int'(digit_o), d);
    chk("R5 scan clock low when disabled", int'(scan_clk_o), 0);
    ext_pulse();
    chk("R5 one external edge one step", int'(digit_o), (d % ND) + 1);

    // Vector walk: R2, R3, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      latch_busy_i = 1'b1;
      result_i = to_bcd(VEC_VAL[i]);
      overflow_i = VEC_OVF[i];
      @(negedge clk);
      chk("R7 busy drops data_good", int'(data_good_o), 0);
      chk("R9 overflow low without data_good", int'(overflow_o), 0);
      latch_busy_i = 1'b0;
      ext_pulse();
      chk("R8 data_good waits for position 0", int'(data_good_o), slot0_o ? 1 : 0);
      while (!slot0_o) ext_pulse();
      chk("R8 data_good back at position 0", int'(data_good_o), 1);
      chk("R8 overflow captured", int'(overflow_o), int'(VEC_OVF[i]));
      for (int k = 0; k < ND; k++) begin
        chk("R2 digit value", int'(digit_o), dec_digit(VEC_VAL[i], k));
        chk("R3 marker position", int'(slot0_o), (k == 0) ? 1 : 0);
        ext_pulse();
      end
      chk("R3 wrap to position 0", int'(slot0_o), 1);
    end

    // R6: return to internal, first step on edge DIV+2
    result_i = to_bcd(RAMP);
    overflow_i = 1'b0;
    ext_pulse();
    d = int'(digit_o);
    @(negedge clk) int_scan_dis_i = 1'b0;
    repeat (DIV + 1) @(negedge clk);
    chk("R6 no early step after switch", int'(digit_o), d);
    @(negedge clk);
    chk("R6 single step after switch", int'(digit_o), (d % ND) + 1);
    repeat (DIV) @(negedge clk);
    chk("R6 next step one period later", int'(digit_o), ((d + 1) % ND) + 1);

    // R1: reset in mid-scan
    while (slot0_o) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-scan reset returns to slot0", int'(slot0_o), 1);
    chk("R1 mid-scan reset drops data_good", int'(data_good_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule